// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a memory-mapped serial transmitter/receiver for a 32-bit register bus. Software picks a frame shape (eight data bits, optional even or odd parity, one or two stop bits) and a bit-rate divider. It then exchanges characters through two eight-entry queues. The transmit queue feeds a shift engine that drives `txLine`. A mid-bit sampling receiver fills the receive queue from `rxLine`, or from the block's own transmit output when the internal loop is enabled.

Three interrupt lines are provided: receive, transmit and fault. The receive and transmit lines each have a programmable fill threshold. Every register can also be written through a clear alias and a set alias, so single bits can be changed without a read-modify-write. A module-enable bit sits above the per-direction enables. An idle flag tells software when the last stop bit has left the line.

Top module: `serial_port_regs`

## Requirements
- R1: Registers sit at 0x00 (mode), 0x10 (status/control), 0x20 (transmit data, write), 0x30 (receive data, read) and 0x40 (divider). A write to base+0x4 clears the bits written as 1. A write to base+0x8 sets those bits. A write to the base replaces the value. Accesses with address bit 7 or bits 1:0 nonzero are ignored. Mode bits with no function still read back as written.
- R2: After reset every register is zero, status reads 0x0000_0100, `txLine` is high and all three interrupts are low.
- R3: A frame is: a low start bit, then 8 data bits LSB first, then a parity bit if mode[2:1] is 01 (even) or 10 (odd), then one high stop bit, or two when mode[0]=1. One bit lasts 16*(divider+1) clocks.
- R4: The transmit queue holds 8 characters and sends them in write order. Status bit 9 reads 1 when it is full, and a write while full is dropped. No new character starts while status bit 10 (transmit enable) is 0.
- R5: Status bit 8 reads 1 only when the transmit queue is empty and the shifter is idle.
- R6: With status bit 12 set, the receiver samples each bit at its middle. Status bit 0 shows that data is waiting. A read of 0x30 returns the oldest character in bits 7:0 and removes it. A read of an empty queue returns 0.
- R7: Status bit 3 (parity error) and bit 2 (stop bit sampled low) describe the character at the head of the receive queue.
- R8: A character that completes while the receive queue holds 8 is dropped and sets status bit 1. That bit stays set until software clears it, with a direct write of 0 to bit 1 or a clear-alias write of 1. Writing 1 to it has no effect.
- R9: Status bits 7:6 set the receive interrupt level: 00 means at least one character, 01 means at least 4, and 1x means 8. The receive interrupt is also high while bit 1 is set.
- R10: Status bits 15:14 set the transmit interrupt: 00 means the queue is not full, 01 means status bit 8 is set, and 1x means the queue is empty.
- R11: The fault interrupt is high while bit 1 is set, or while the head character has a parity or stop error.
- R12: While status bit 11 is set, `txLine` is low. When the bit is cleared, the line goes high and the transmitter stays busy (bit 8 = 0) for one stop time before it sends anything.
- R13: With mode bit 6 set, the receiver listens to the transmit output and `rxLine` has no effect.
- R14: With mode bit 15 at 0, both queues are emptied, both engines are idle, `txLine` is high and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| rxLine | input | 1 | Serial input |
| txLine | output | 1 | Serial output |
| irqRx | output | 1 | Receive interrupt |
| irqTx | output | 1 | Transmit interrupt |
| irqFault | output | 1 | Error interrupt |

## Verification
The frame engine is swept over all six parity/stop combinations, each with its own data values. The sampled line bits are compared against a frame built arithmetically, which separates bit order, parity polarity and stop count. The gap between back-to-back start edges tells one stop bit from two.

Externally driven frames carry deliberate parity and stop faults. Together with a ninth character into a full queue, they separate head-of-queue error tracking from the sticky overrun. Fill levels of 3, 4 and 8 characters tell the interrupt thresholds apart. Break, queue-full, and module-off flushing are each probed at the ports.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W    = 8;
  localparam int OVS       = 16;          // samples per bit
  localparam int FRAME_MAX = DATA_W + 4;  // start + data + parity + two stops

  typedef struct packed {
    logic       on;
    logic       txEn;
    logic       rxEn;
    logic       brk;
    logic       loop;
    logic [1:0] parSel;
    logic       stop2;
  } cfg_t;

  typedef struct packed {
    logic              txPush;
    logic [DATA_W-1:0] txData;
    logic              rxPop;
  } strobe_t;
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0; wrPtr <= '0; count <= '0;
    end else if (flush) begin
      rdPtr <= '0; wrPtr <= '0; count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  // R4 / R8: a push into a full queue leaves it full and loses the entry
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (count == CW'(DEPTH) && push && !pop && !flush) |=> (count == CW'(DEPTH)));
  // R6: popping an empty queue does not wrap the count
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && pop && !push && !flush) |=> (count == '0));
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfg_t                       cfg,
  input  strobe_t                    stb,
  input  logic [DIV_W-1:0]           baudDiv,
  input  logic                       rxPin,
  output logic                       txPin,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic                       txBusy,
  output logic [DATA_W-1:0]          rxHeadData,
  output logic                       rxHeadPerr,
  output logic                       rxHeadFerr,
  output logic                       overrunEvt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(OVS);

  // bit-rate prescaler: one tick per sample slot
  logic [DIV_W-1:0] preCnt;
  logic             tick;
  assign tick = (preCnt == baudDiv);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (!cfg.on) preCnt <= '0;
    else              preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  logic parEn;
  assign parEn = (cfg.parSel == 2'b01) || (cfg.parSel == 2'b10);

  // ---------------- transmit ----------------
  logic [DATA_W-1:0]    txHead;
  logic [FRAME_MAX-1:0] txShift, txFrame;
  logic [3:0]           txBitsLeft, txLen;
  logic [SW-1:0]        txSub;
  logic                 brkQ, brkFall, txStart;

  sp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(!cfg.on), .push(stb.txPush), .pop(txStart),
    .din(stb.txData), .head(txHead), .count(txCount));

  always_comb begin
    txFrame           = '1;
    txFrame[0]        = 1'b0;
    txFrame[DATA_W:1] = txHead;
    if (parEn) txFrame[DATA_W+1] = (cfg.parSel == 2'b10) ? ~^txHead : ^txHead;
  end
  assign txLen   = 4'(DATA_W + 2) + {3'b0, parEn} + {3'b0, cfg.stop2};
  assign txBusy  = (txBitsLeft != '0);
  assign brkFall = brkQ && !cfg.brk && cfg.on;
  assign txStart = cfg.on && cfg.txEn && !cfg.brk && !brkFall && !txBusy && (txCount != '0);
  assign txPin   = (cfg.on && cfg.brk) ? 1'b0 : (txBusy ? txShift[0] : 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1; txBitsLeft <= '0; txSub <= '0; brkQ <= 1'b0;
    end else begin
      brkQ <= cfg.brk;
      if (!cfg.on) begin
        txBitsLeft <= '0; txSub <= '0;
      end else if (brkFall) begin
        txShift    <= '1;                       // guard: line high for a stop time
        txBitsLeft <= cfg.stop2 ? 4'd2 : 4'd1;
        txSub      <= '0;
      end else if (txStart) begin
        txShift <= txFrame; txBitsLeft <= txLen; txSub <= '0;
      end else if (txBusy && tick) begin
        txSub <= txSub + 1'b1;
        if (txSub == SW'(OVS - 1)) begin
          txShift    <= {1'b1, txShift[FRAME_MAX-1:1]};
          txBitsLeft <= txBitsLeft - 1'b1;
        end
      end
    end
  end

  // ---------------- receive ----------------
  logic [1:0]        rxSync;
  logic              rxPrev, rxS, rxActive, rxParBad, sampleNow, rxDone, rxPush;
  logic [SW-1:0]     rxSub;
  logic [3:0]        rxIdx, stopIdx;
  logic [DATA_W-1:0] rxData;
  logic              expPar;

  assign rxS       = rxSync[1];
  assign stopIdx   = parEn ? 4'(DATA_W + 2) : 4'(DATA_W + 1);
  assign expPar    = (cfg.parSel == 2'b10) ? ~^rxData : ^rxData;
  assign sampleNow = rxActive && tick && (rxSub == SW'(OVS / 2 - 1));
  assign rxDone    = sampleNow && (rxIdx == stopIdx) && cfg.on && cfg.rxEn;
  assign rxPush    = rxDone && (rxCount != CW'(DEPTH));
  assign overrunEvt = rxDone && (rxCount == CW'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11; rxPrev <= 1'b1; rxActive <= 1'b0; rxSub <= '0;
      rxIdx <= '0; rxData <= '0; rxParBad <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], cfg.loop ? txPin : rxPin};
      rxPrev <= rxS;
      if (!cfg.on || !cfg.rxEn) begin
        rxActive <= 1'b0; rxSub <= '0; rxIdx <= '0;
      end else if (!rxActive) begin
        if (rxPrev && !rxS) begin
          rxActive <= 1'b1; rxSub <= '0; rxIdx <= '0; rxParBad <= 1'b0;
        end
      end else begin
        if (tick) rxSub <= rxSub + 1'b1;
        if (sampleNow) begin
          rxIdx <= rxIdx + 1'b1;
          if (rxIdx == '0) begin
            if (rxS) rxActive <= 1'b0;          // false start
          end else if (rxIdx <= 4'(DATA_W)) begin
            rxData <= {rxS, rxData[DATA_W-1:1]};
          end else if (parEn && rxIdx == 4'(DATA_W + 1)) begin
            rxParBad <= (rxS != expPar);
          end
          if (rxIdx == stopIdx) rxActive <= 1'b0;
        end
      end
    end
  end

  logic [DATA_W+1:0] rxHeadWord;
  sp_fifo #(.W(DATA_W + 2), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(!cfg.on), .push(rxPush), .pop(stb.rxPop),
    .din({rxParBad && parEn, !rxS, rxData}), .head(rxHeadWord), .count(rxCount));
  assign rxHeadPerr = rxHeadWord[DATA_W+1];
  assign rxHeadFerr = rxHeadWord[DATA_W];
  assign rxHeadData = rxHeadWord[DATA_W-1:0];

  // R12: releasing break always starts a guard period on the next cycle
  assert_break_guard_R12: assert property (@(posedge clk) disable iff (!rstN)
    brkFall |=> txBusy);
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [7:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic                       txBusy,
  input  logic [DATA_W-1:0]          rxHeadData,
  input  logic                       rxHeadPerr,
  input  logic                       rxHeadFerr,
  input  logic                       overrunEvt,
  output cfg_t                       cfg,
  output strobe_t                    stb,
  output logic [DIV_W-1:0]           baudDiv,
  output logic                       irqRx,
  output logic                       irqTx,
  output logic                       irqFault
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [15:0] STA_WMASK = 16'hFCF0;

  logic [15:0] modeReg, staReg;
  logic        oerr, addrOk, wrHit, staWr, oerrClr, txFull, trmt, rxAvail;
  logic [2:0]  regSel;
  logic [1:0]  kind;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] k);
    case (k)
      2'd1:    merge = old & ~wd;
      2'd2:    merge = old | wd;
      default: merge = wd;
    endcase
  endfunction

  assign addrOk = !busAddr[7] && (busAddr[1:0] == 2'b00);
  assign regSel = busAddr[6:4];
  assign kind   = busAddr[3:2];
  assign wrHit  = busSel && busWrite && addrOk;
  assign staWr  = wrHit && (regSel == 3'd1);
  assign oerrClr = staWr && ((kind == 2'd1) ? busWdata[1] : (kind != 2'd2) && !busWdata[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0; staReg <= '0; baudDiv <= '0; oerr <= 1'b0;
    end else begin
      if (wrHit && regSel == 3'd0) modeReg <= merge({16'b0, modeReg}, busWdata, kind)[15:0];
      if (staWr) staReg <= merge({16'b0, staReg}, busWdata, kind)[15:0] & STA_WMASK;
      if (wrHit && regSel == 3'd4) baudDiv <= merge(32'(baudDiv), busWdata, kind)[DIV_W-1:0];
      if (overrunEvt)   oerr <= 1'b1;
      else if (oerrClr) oerr <= 1'b0;
    end
  end

  assign cfg.on     = modeReg[15];
  assign cfg.loop   = modeReg[6];
  assign cfg.parSel = modeReg[2:1];
  assign cfg.stop2  = modeReg[0];
  assign cfg.rxEn   = staReg[12];
  assign cfg.brk    = staReg[11];
  assign cfg.txEn   = staReg[10];

  assign stb.txPush = wrHit && (regSel == 3'd2) && (kind == 2'd0);
  assign stb.txData = busWdata[DATA_W-1:0];
  assign stb.rxPop  = busSel && !busWrite && addrOk && (regSel == 3'd3) && (kind == 2'd0);

  assign txFull  = (txCount == CW'(DEPTH));
  assign trmt    = (txCount == '0) && !txBusy;
  assign rxAvail = (rxCount != '0);

  always_comb begin
    busRdata = '0;
    if (busSel && addrOk) begin
      case (regSel)
        3'd0: busRdata = {16'b0, modeReg};
        3'd1: busRdata = {16'b0, staReg[15:10], txFull, trmt, staReg[7:4],
                          rxAvail && rxHeadPerr, rxAvail && rxHeadFerr, oerr, rxAvail};
        3'd3: busRdata = rxAvail ? 32'(rxHeadData) : '0;
        3'd4: busRdata = 32'(baudDiv);
        default: busRdata = '0;
      endcase
    end
  end

  logic rxLevel, txLevel;
  always_comb begin
    case (staReg[7:6])
      2'b00:   rxLevel = rxAvail;
      2'b01:   rxLevel = (rxCount >= CW'(DEPTH / 2));
      default: rxLevel = (rxCount == CW'(DEPTH));
    endcase
    case (staReg[15:14])
      2'b00:   txLevel = !txFull;
      2'b01:   txLevel = trmt;
      default: txLevel = (txCount == '0);
    endcase
  end
  assign irqRx    = cfg.on && (rxLevel || oerr);
  assign irqTx    = cfg.on && txLevel;
  assign irqFault = cfg.on && (oerr || (rxAvail && (rxHeadPerr || rxHeadFerr)));

  // R8: a dropped character always leaves the overrun flag set
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrunEvt |=> oerr);
  // R8: without a clearing write the flag never drops
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (oerr && !oerrClr) |=> oerr);
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxLine,
  output logic        txLine,
  output logic        irqRx,
  output logic        irqTx,
  output logic        irqFault
);
  localparam int CW = $clog2(DEPTH + 1);

  cfg_t              cfg;
  strobe_t           stb;
  logic [DIV_W-1:0]  baudDiv;
  logic [CW-1:0]     txCount, rxCount;
  logic              txBusy, rxHeadPerr, rxHeadFerr, overrunEvt;
  logic [DATA_W-1:0] rxHeadData;

  sp_ctrl #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txCount(txCount), .rxCount(rxCount),
    .txBusy(txBusy), .rxHeadData(rxHeadData), .rxHeadPerr(rxHeadPerr),
    .rxHeadFerr(rxHeadFerr), .overrunEvt(overrunEvt), .cfg(cfg), .stb(stb),
    .baudDiv(baudDiv), .irqRx(irqRx), .irqTx(irqTx), .irqFault(irqFault));

  sp_datapath #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .baudDiv(baudDiv), .rxPin(rxLine),
    .txPin(txLine), .txCount(txCount), .rxCount(rxCount), .txBusy(txBusy),
    .rxHeadData(rxHeadData), .rxHeadPerr(rxHeadPerr), .rxHeadFerr(rxHeadFerr),
    .overrunEvt(overrunEvt));
endmodule

// File: tb/serial_port_regs_tb.sv
`timescale 1ns/1ps
module serial_port_regs_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        rxLine = 1'b1, txLine, irqRx, irqTx, irqFault;
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_port_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine),
    .irqRx(irqRx), .irqTx(irqTx), .irqFault(irqFault));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    s = 0;
    while (!s[8]) busRd(8'h10, s);
  endtask

  // drive one frame on rxLine, 16 clocks per bit (divider 0)
  task automatic sendSer(input logic [7:0] d, input bit parEn, input bit parOdd,
                         input bit flip, input logic stopVal);
    logic p;
    p = (parOdd ? ~^d : ^d) ^ flip;
    @(negedge clk); rxLine = 0; waitClk(16);
    for (int i = 0; i < 8; i++) begin rxLine = d[i]; waitClk(16); end
    if (parEn) begin rxLine = p; waitClk(16); end
    rxLine = stopVal; waitClk(16);
    rxLine = 1; waitClk(16);
  endtask

  // sample txLine at bit middles after the next falling edge
  task automatic grabFrame(input int nb, output logic [15:0] bits, output int tFall);
    bits = '1;
    while (txLine) @(negedge clk);
    tFall = cyc;
    waitClk(7);
    for (int i = 0; i < nb; i++) begin
      bits[i] = txLine;
      if (i != nb - 1) waitClk(16);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] bits, expBits;
    int t1, t2, nb;
    logic [7:0] d1, d2;

    waitClk(3); rstN = 1; waitClk(2);

    // R2 reset state
    busRd(8'h10, r); check("R2 status", r, 32'h100);
    busRd(8'h00, r); check("R2 mode", r, 0);
    busRd(8'h40, r); check("R2 divider", r, 0);
    check("R2 lines", {txLine, irqRx, irqTx, irqFault}, 4'b1000);

    // R1 aliases and stored-only bits
    busWr(8'h00, 32'h1030); busWr(8'h08, 32'h8000); busWr(8'h04, 32'h0010);
    busRd(8'h00, r); check("R1 mode alias", r, 32'h9020);
    busWr(8'h00, 32'h0);
    busWr(8'h40, 32'h1234); busWr(8'h44, 32'h0030); busWr(8'h48, 32'h0001);
    busRd(8'h40, r); check("R1 divider alias", r, 32'h1205);
    busWr(8'h41, 32'h0077); busRd(8'h40, r); check("R1 misaligned ignored", r, 32'h1205);
    busWr(8'h40, 32'h0);

    // R3/R13/R6 frame sweep in loopback, rxLine held low (must be ignored)
    rxLine = 0;
    for (int cfgI = 0; cfgI < 6; cfgI++) begin
      int par, st;
      par = cfgI / 2; st = cfgI % 2;
      d1 = 8'hA5 ^ 8'(cfgI * 37); d2 = 8'h3C + 8'(cfgI);
      busWr(8'h10, 32'h1400);
      busWr(8'h00, 32'h8040 | (par << 1) | st);
      busWr(8'h20, {24'b0, d1}); busWr(8'h20, {24'b0, d2});
      nb = 10 + (par != 0 ? 1 : 0) + st;
      expBits = '1; expBits[0] = 0; expBits[8:1] = d1;
      if (par == 1) expBits[9] = ^d1;
      if (par == 2) expBits[9] = ~^d1;
      grabFrame(nb, bits, t1);
      check($sformatf("R3 frame bits par=%0d stop2=%0d", par, st), bits, expBits);
      grabFrame(nb, bits, t2);
      check($sformatf("R3 frame length par=%0d stop2=%0d", par, st),
            ((t2 - t1) >= 16 * nb && (t2 - t1) <= 16 * nb + 2), 1);
      waitIdle(); waitClk(40);
      busRd(8'h10, r); check("R7 no errors on loopback", r[3:0], 4'b0001);
      busRd(8'h30, r); check("R13 loopback char 1", r, d1);
      busRd(8'h30, r); check("R4 loopback char 2 order", r, d2);
    end

    // R4/R5/R10 transmit queue full
    busWr(8'h10, 32'h1000);
    busWr(8'h00, 32'h8040);
    check("R10 txirq not full", irqTx, 1);
    for (int i = 0; i < 8; i++) busWr(8'h20, 32'(i * 17 + 1));
    busRd(8'h10, r); check("R4 full flag, R5 not idle", r[9:8], 2'b10);
    check("R10 txirq low when full", irqTx, 0);
    busWr(8'h20, 32'hEE);
    busWr(8'h18, 32'h4000);
    check("R10 txirq mode01 busy", irqTx, 0);
    busWr(8'h18, 32'h0400);
    waitIdle(); waitClk(40);
    check("R10 txirq mode01 idle", irqTx, 1);
    check("R9 rxirq mode00", irqRx, 1);
    for (int i = 0; i < 8; i++) begin
      busRd(8'h30, r); check($sformatf("R4 queue order %0d", i), r, 32'(i * 17 + 1));
    end
    busRd(8'h10, r); check("R4 ninth dropped", r[1:0], 2'b00);
    busRd(8'h30, r); check("R6 empty read", r, 0);

    // R9/R8/R11 receive levels and overrun from external line
    rxLine = 1;
    busWr(8'h00, 32'h8000);
    busWr(8'h10, 32'h1040);
    waitClk(20);
    for (int i = 0; i < 3; i++) sendSer(8'(8'h40 + i), 0, 0, 0, 1);
    check("R9 level01 at 3", irqRx, 0);
    sendSer(8'h43, 0, 0, 0, 1);
    check("R9 level01 at 4", irqRx, 1);
    busWr(8'h18, 32'h0080); busWr(8'h14, 32'h0040);
    check("R9 level1x at 4", irqRx, 0);
    for (int i = 4; i < 8; i++) sendSer(8'(8'h40 + i), 0, 0, 0, 1);
    check("R9 level1x at 8", irqRx, 1);
    sendSer(8'h99, 0, 0, 0, 1);
    busRd(8'h10, r); check("R8 overrun set", r[1], 1);
    for (int i = 0; i < 8; i++) begin
      busRd(8'h30, r); check($sformatf("R8 kept char %0d", i), r, 32'(8'h40 + i));
    end
    check("R9 rxirq held by overrun", irqRx, 1);
    check("R11 fault on overrun", irqFault, 1);
    busWr(8'h10, 32'h1082);
    busRd(8'h10, r); check("R8 write one keeps flag", r[1], 1);
    busWr(8'h14, 32'h0002);
    busRd(8'h10, r); check("R8 clear alias", r[1], 0);
    check("R8 rxirq after clear", irqRx, 0);
    check("R11 fault after clear", irqFault, 0);

    // R7/R11 head-of-queue error flags (even parity)
    busWr(8'h10, 32'h1000);
    busWr(8'h00, 32'h8002);
    sendSer(8'h5A, 1, 0, 1, 1);
    sendSer(8'hC3, 1, 0, 0, 0);
    busRd(8'h10, r); check("R7 head parity error", r[3:2], 2'b10);
    check("R11 fault on parity", irqFault, 1);
    busRd(8'h30, r); check("R7 char with parity error", r, 32'h5A);
    busRd(8'h10, r); check("R7 head stop error", r[3:2], 2'b01);
    busRd(8'h30, r); check("R7 char with stop error", r, 32'hC3);
    check("R11 fault clears when empty", irqFault, 0);

    // R10 mode 1x: empty queue
    busWr(8'h00, 32'h8000);
    busWr(8'h10, 32'h8000);
    check("R10 mode1x empty", irqTx, 1);
    busWr(8'h20, 32'h11);
    check("R10 mode1x holding", irqTx, 0);

    // R14 module off flushes
    busRd(8'h10, r); check("R14 queued before off", r[8], 0);
    busWr(8'h00, 32'h0);
    busRd(8'h10, r); check("R14 idle when off", r[9:8], 2'b01);
    check("R14 irqs off", {irqRx, irqTx, irqFault}, 3'b000);
    busWr(8'h00, 32'h8000);
    busRd(8'h10, r); check("R14 flushed after on", r[8], 1);

    // R12 break
    busWr(8'h10, 32'h0400);
    busWr(8'h18, 32'h0800);
    check("R12 break low", txLine, 0);
    waitClk(50);
    check("R12 break held", txLine, 0);
    busWr(8'h14, 32'h0800);
    waitClk(2);
    check("R12 line high after break", txLine, 1);
    busRd(8'h10, r); check("R12 guard busy", r[8], 0);
    waitClk(20);
    busRd(8'h10, r); check("R12 guard over", r[8], 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule